// File: doc/BRIEF.md
# Access-Policy Register Field Bank

This block holds a small array of register fields behind a plain synchronous bus. The bus has one shared address, a write strobe with write data, and a read strobe. Read data comes back with a valid flag on the cycle after the read strobe. Each field sits at the address equal to its index. Each field has a fixed access policy, chosen by a parameter code at build time. The policy decides three things: how a bus write changes the stored bits, what a bus read returns, and whether the read itself changes the field.

A read and a write may hit the same field in one cycle, because the address is shared. In that case the read returns the value held before the edge, and the write action wins over any read side effect. A field with a write-once policy keeps an internal flag that records whether it has already accepted its single write. Reset clears that flag.

Top module: `polfield_bank`

## Requirements
- R1: A synchronous active-high `rst` loads each field with its own `RESET_VEC` slice (bits `[i*DATA_W +: DATA_W]`) and re-arms every write-once field.
- R2: `rd_valid` is high exactly one cycle after `rd_en`. When it is low, `rd_data` is zero. A read of an address at or above `NUM_FIELDS` returns zero, and a write to such an address changes nothing.
- R3: Field i uses the code `POLICY_VEC[i*5 +: 5]`.
  - Code 0 (read-write) stores the written data.
  - Code 1 (read-only) ignores writes.
  - Code 2 (write-only) stores writes and always reads as zero.
  - Codes 17 to 31 behave as code 0.
- R4: Code 3 clears the bits written as 1. Code 4 clears the bits written as 0. Code 5 sets the bits written as 1. Code 6 sets the bits written as 0. All other bits hold.
- R5: Code 7 inverts the bits written as 1. Code 8 inverts the bits written as 0.
- R6: Code 9 (write-once) stores only the first write after reset and ignores every later write until the next reset.
- R7: Code 10 returns its value and then becomes all zeros. Code 11 returns its value and then becomes all ones. Writes to either code are ignored.
- R8: Combined policies:
  - Code 12 stores writes and clears on read.
  - Code 13 stores writes and sets on read.
  - Code 14 sets on write and clears on read.
  - Code 15 clears on write and sets on read.
- R9: Code 16 returns to its reset value on any write, whatever the data.
- R10: A read that shares its cycle with a write returns the value held before that write, and the write action takes priority over the read side effect. Read side effects occur only for a read strobe to the field's own address. An idle cycle changes no field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Field index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds the bank with 17 fields of 8 bits and a 5-bit address, with field i given code i. This puts every policy in one instance, and leaves 15 unmapped addresses for the out-of-range read checks. With 8 bits per field, a short fixed set of data patterns sweeps every field through each write, read and combined read-write cycle: all-zeros, all-ones, alternating bits, nibble halves and sparse bits. A distinct reset value per field lets write-to-reset and the reset load be told apart from stored data. A second reset in the middle of the run shows that a write-once field is re-armed.

// File: rtl/pfb_pkg.sv
`timescale 1ns/1ps
package pfb_pkg;
  localparam int POL_W = 5;

  typedef enum logic [POL_W-1:0] {
    PF_RW    = 5'd0,
    PF_RO    = 5'd1,
    PF_WO    = 5'd2,
    PF_W1C   = 5'd3,
    PF_W0C   = 5'd4,
    PF_W1S   = 5'd5,
    PF_W0S   = 5'd6,
    PF_W1T   = 5'd7,
    PF_W0T   = 5'd8,
    PF_WONCE = 5'd9,
    PF_RC    = 5'd10,
    PF_RS    = 5'd11,
    PF_WRC   = 5'd12,
    PF_WRS   = 5'd13,
    PF_WSRC  = 5'd14,
    PF_WCRS  = 5'd15,
    PF_WRES  = 5'd16
  } policy_e;
endpackage

// File: rtl/polfield_cell.sv
`timescale 1ns/1ps
// One field: stored bits, policy-driven next state, read view.
module polfield_cell #(
  parameter int              W         = 8,
  parameter pfb_pkg::policy_e POLICY   = pfb_pkg::PF_RW,
  parameter logic [W-1:0]    RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic         rd_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] rview
);
  import pfb_pkg::*;

  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         taken;   // write-once: first write already accepted
  logic [W-1:0] q_nxt;

  generate
    if (POLICY == PF_WONCE) begin : g_once
      logic taken_q;
      always_ff @(posedge clk) begin
        if (rst)         taken_q <= 1'b0;
        else if (wr_hit) taken_q <= 1'b1;
      end
      assign taken = taken_q;
    end else begin : g_nonce
      assign taken = 1'b0;
    end

    if (POLICY == PF_WO) begin : g_wo_view
      assign rview = '0;
    end else begin : g_view
      assign rview = q;
    end
  endgenerate

  // write action always outranks the read side effect
  always_comb begin
    q_nxt = q;
    case (POLICY)
      PF_RO:    q_nxt = q;
      PF_W1C:   if (wr_hit) q_nxt = q & ~wdata;
      PF_W0C:   if (wr_hit) q_nxt = q & wdata;
      PF_W1S:   if (wr_hit) q_nxt = q | wdata;
      PF_W0S:   if (wr_hit) q_nxt = q | ~wdata;
      PF_W1T:   if (wr_hit) q_nxt = q ^ wdata;
      PF_W0T:   if (wr_hit) q_nxt = q ^ ~wdata;
      PF_WONCE: if (wr_hit && !taken) q_nxt = wdata;
      PF_RC:    if (rd_hit) q_nxt = '0;
      PF_RS:    if (rd_hit) q_nxt = ONES;
      PF_WRC: begin
        if (wr_hit)      q_nxt = wdata;
        else if (rd_hit) q_nxt = '0;
      end
      PF_WRS: begin
        if (wr_hit)      q_nxt = wdata;
        else if (rd_hit) q_nxt = ONES;
      end
      PF_WSRC: begin
        if (wr_hit)      q_nxt = ONES;
        else if (rd_hit) q_nxt = '0;
      end
      PF_WCRS: begin
        if (wr_hit)      q_nxt = '0;
        else if (rd_hit) q_nxt = ONES;
      end
      PF_WRES:  if (wr_hit) q_nxt = RESET_VAL;
      default:  if (wr_hit) q_nxt = wdata;   // RW, WO, unused codes
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/polfield_rdmux.sv
`timescale 1ns/1ps
// Registered read port: select by address, zero for unmapped or idle.
module polfield_rdmux #(
  parameter int NUM_FIELDS = 17,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         rd_en,
  input  logic [NUM_FIELDS*DATA_W-1:0] rd_vals,
  output logic                         rd_valid,
  output logic [DATA_W-1:0]            rd_data
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (int'(addr) == i) sel = rd_vals[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? sel : '0;
    end
  end
endmodule

// File: rtl/polfield_bank.sv
`timescale 1ns/1ps
module polfield_bank #(
  parameter int NUM_FIELDS = 17,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5,
  parameter logic [NUM_FIELDS*pfb_pkg::POL_W-1:0] POLICY_VEC = '0,
  parameter logic [NUM_FIELDS*DATA_W-1:0]         RESET_VEC  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PW = pfb_pkg::POL_W;

  logic [NUM_FIELDS*DATA_W-1:0] field_q;
  logic [NUM_FIELDS*DATA_W-1:0] rd_vals;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    polfield_cell #(
      .W         (DATA_W),
      .POLICY    (pfb_pkg::policy_e'(POLICY_VEC[i*PW +: PW])),
      .RESET_VAL (RESET_VEC[i*DATA_W +: DATA_W])
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (wr_en && (addr == ADDR_W'(i))),
      .rd_hit (rd_en && (addr == ADDR_W'(i))),
      .wdata  (wr_data),
      .q      (field_q[i*DATA_W +: DATA_W]),
      .rview  (rd_vals[i*DATA_W +: DATA_W])
    );
  end

  polfield_rdmux #(
    .NUM_FIELDS (NUM_FIELDS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .rd_en    (rd_en),
    .rd_vals  (rd_vals),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/polfield_bank_chk.sv
`timescale 1ns/1ps
module polfield_bank_chk #(
  parameter int NUM_FIELDS = 17,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5,
  parameter logic [NUM_FIELDS*DATA_W-1:0] RESET_VEC = '0
) (
  input logic                         clk,
  input logic                         rst,
  input logic [ADDR_W-1:0]            addr,
  input logic                         wr_en,
  input logic                         rd_en,
  input logic                         rd_valid,
  input logic [DATA_W-1:0]            rd_data,
  input logic [NUM_FIELDS*DATA_W-1:0] field_q
);
  // R2
  rd_valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R2
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R2
  rd_data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0);

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(addr) >= NUM_FIELDS) |=> rd_data == '0);

  // R1
  reset_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> field_q == RESET_VEC);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en) |=> $stable(field_q));
endmodule

bind polfield_bank polfield_bank_chk #(
  .NUM_FIELDS (NUM_FIELDS),
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .RESET_VEC  (RESET_VEC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .field_q  (field_q)
);

// File: tb/polfield_bank_bench.sv
`timescale 1ns/1ps
module polfield_bank_bench;
  localparam int NF = 17;
  localparam int DW = 8;
  localparam int AW = 5;

  function automatic logic [NF*5-1:0] mk_pol();
    logic [NF*5-1:0] v;
    v = '0;
    for (int i = 0; i < NF; i++) v[i*5 +: 5] = 5'(i);
    return v;
  endfunction

  function automatic logic [7:0] rv(int i);
    return 8'(8'h5C ^ (i * 37));
  endfunction

  function automatic logic [NF*DW-1:0] mk_rst();
    logic [NF*DW-1:0] v;
    v = '0;
    for (int i = 0; i < NF; i++) v[i*DW +: DW] = rv(i);
    return v;
  endfunction

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  logic [7:0] mdl [NF];
  bit         done[NF];

  always #4 clk = ~clk;

  polfield_bank #(
    .NUM_FIELDS (NF),
    .DATA_W     (DW),
    .ADDR_W     (AW),
    .POLICY_VEC (mk_pol()),
    .RESET_VEC  (mk_rst())
  ) u_polfield_bank (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // next value from the requirement text; field i has code i
  function automatic logic [7:0] nxt(int p, logic [7:0] q, bit we,
                                     logic [7:0] wd, bit re, bit dn);
    case (p)
      0, 2: return we ? wd : q;
      1:    return q;
      3:    return we ? (q & ~wd) : q;
      4:    return we ? (q & wd) : q;
      5:    return we ? (q | wd) : q;
      6:    return we ? (q | ~wd) : q;
      7:    return we ? (q ^ wd) : q;
      8:    return we ? ~(q ^ wd) : q;
      9:    return (we && !dn) ? wd : q;
      10:   return re ? 8'h00 : q;
      11:   return re ? 8'hFF : q;
      12:   return we ? wd : (re ? 8'h00 : q);
      13:   return we ? wd : (re ? 8'hFF : q);
      14:   return we ? 8'hFF : (re ? 8'h00 : q);
      15:   return we ? 8'h00 : (re ? 8'hFF : q);
      16:   return we ? rv(p) : q;
      default: return q;
    endcase
  endfunction

  function automatic string tag_of(int p);
    if (p <= 2)  return "R3";
    if (p <= 6)  return "R4";
    if (p <= 8)  return "R5";
    if (p == 9)  return "R6";
    if (p <= 11) return "R7";
    if (p <= 15) return "R8";
    return "R9";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NF; i++) begin
      mdl[i]  = rv(i);
      done[i] = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic op(int a, bit we, logic [7:0] wd, bit re, string tag);
    logic [7:0] exp_d;
    @(negedge clk);
    addr = AW'(a); wr_en = we; wr_data = wd; rd_en = re;
    exp_d = 8'h00;
    if (re && a < NF && a != 2) exp_d = mdl[a];
    if (a < NF) begin
      mdl[a] = nxt(a, mdl[a], we, wd, re, done[a]);
      if (a == 9 && we) done[a] = 1'b1;
    end
    @(negedge clk);
    vectors++;
    if (rd_valid !== re || rd_data !== exp_d) begin
      fails++;
      $display("FAIL %s addr=%0d we=%0d re=%0d: valid=%0d data=%h, expected valid=%0d data=%h",
               tag, a, we, re, rd_valid, rd_data, re, exp_d);
    end
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    logic [7:0] pats [8];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h0F, 8'hF0, 8'h3C, 8'h81};
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    vectors++;
    if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
      fails++;
      $display("FAIL R1 in reset: valid=%0d data=%h, expected valid=0 data=00",
               rd_valid, rd_data);
    end
    rst = 1'b0;
    model_reset();

    // R1: every field holds its reset value
    for (int f = 0; f < NF; f++) op(f, 1'b0, 8'h00, 1'b1, "R1");
    // R2: unmapped reads and writes
    for (int a = NF; a < 32; a++) begin
      op(a, 1'b1, 8'hFF, 1'b0, "R2");
      op(a, 1'b0, 8'h00, 1'b1, "R2");
    end

    // sweep every policy with every pattern
    for (int f = 0; f < NF; f++) begin
      for (int k = 0; k < 8; k++) begin
        op(f, 1'b1, pats[k], 1'b0, tag_of(f));
        op(f, 1'b0, 8'h00, 1'b1, tag_of(f));
        op(f, 1'b1, ~pats[k], 1'b1, "R10");
        op(f, 1'b0, 8'h00, 1'b1, tag_of(f));
      end
    end

    // R6: write-once is re-armed by reset
    do_reset();
    op(9, 1'b1, 8'hAA, 1'b0, "R6");
    op(9, 1'b0, 8'h00, 1'b1, "R6");
    op(9, 1'b1, 8'h55, 1'b0, "R6");
    op(9, 1'b0, 8'h00, 1'b1, "R6");
    // R1: reset restored everything
    for (int f = 0; f < NF; f++) if (f != 9) op(f, 1'b0, 8'h00, 1'b1, "R1");

    // R10: side effects only on the field's own address
    op(12, 1'b1, 8'hC3, 1'b0, "R10");
    op(13, 1'b0, 8'h00, 1'b1, "R10");
    op(10, 1'b1, 8'h00, 1'b0, "R10");
    repeat (4) @(negedge clk);
    op(12, 1'b0, 8'h00, 1'b1, "R10");
    op(12, 1'b0, 8'h00, 1'b1, "R10");
    // R9: write-to-reset after other data
    op(16, 1'b1, 8'h00, 1'b0, "R9");
    op(16, 1'b0, 8'h00, 1'b1, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule